// File: doc/BRIEF.md
# Oversampled Photon Event Interval Counter

This block measures the time between successive photon detections on a detector pulse line. A fast front end samples the line at eight times the system clock rate and packs the samples into an 8-bit word. One word arrives on every system clock cycle. The block scans each word for rising edges. It also carries the last sample of the previous word forward, so that an edge falling between two words is still caught. For every detected event it reports how many fast sample periods have passed since the event before it.

Intervals are reported in raw sample units with no scaling, and the host converts them to time. Several events can land in one word. To handle this, the output is split into a parameterised number of ordered lanes, and each lane has its own valid strobe. Any edges beyond the lane count are flagged rather than reported, but they still act as the timing reference for the next interval. The running count saturates instead of wrapping, so a very long quiet gap reads as the maximum value.

Top module: `photon_interval_counter`

## Requirements
- R1: While rstN is low, and in the first cycle after it, every bit of intervalValid is 0 and overflowFlag is 0.
- R2: An event is a 0-to-1 change between two time-adjacent samples, where bit 0 of sampleWord is the earliest sample and bit 7 the latest. A line that stays high, or stays low, produces no event and no valid strobe.
- R3: The first event after reset only sets the timing reference. It produces no interval.
- R4: An interval equals the difference in sample positions between an event and the event before it. It counts fast sample periods with no scaling, and it spans any number of words.
- R5: The results for a word appear on the outputs one clock after the word is taken. When a word holds several events, their intervals fill lanes in time order. Lane 0 holds the earliest event, and lane j sits at intervalData[j*CNT_W +: CNT_W].
- R6: When a word holds more events than there are lanes, only the earliest LANES events are reported and overflowFlag is 1 for that cycle. The next reported interval is measured from the last event in that word, including events that were not reported.
- R7: An interval longer than 2^CNT_W-1 samples reads as 2^CNT_W-1. After such an event, counting restarts normally.
- R8: Edges that straddle a word boundary are found by comparing bit 0 with bit 7 of the previous word. Previous bit 7 = 0 followed by bit 0 = 1 is an event. Previous bit 7 = 1 followed by bit 0 = 1 is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one sample word per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| sampleWord | input | 8 | Eight detector samples, bit 0 earliest |
| intervalValid | output | LANES | Per-lane interval strobe, lane 0 earliest |
| intervalData | output | LANES*CNT_W | Per-lane interval in sample periods |
| overflowFlag | output | 1 | More events in the word than lanes |

## Verification
The assertions assume that a word with all eight bits known is presented on every clock, including while reset is held. They make no assumption about the pattern within a word. The in-word gap and overflow checks hold for any bit pattern. The bench drives a defined word at every falling edge from time zero onward, reset included. It uses word patterns with zero, one, two and four events, plus long quiet and long high runs, so that every lane, the boundary comparison and saturation are all reached.

// File: rtl/photon_interval_pkg.sv
package photon_interval_pkg;

  // Deserializer ratio: fast samples per system clock word.
  localparam int PIC_WORD_W = 8;
  localparam int PIC_POS_W = $clog2(PIC_WORD_W);
  // Rising edges need a low sample between them, so a word holds at most half as many.
  localparam int PIC_MAX_LANES = PIC_WORD_W / 2;
  localparam int PIC_LANE_IDX_W = (PIC_MAX_LANES > 1) ? $clog2(PIC_MAX_LANES) : 1;

  // Strobes and positions handed from the edge scanner to the datapath.
  typedef struct packed {
    logic [PIC_MAX_LANES-1:0]                laneHit;
    logic [PIC_MAX_LANES-1:0]                laneFire;
    logic [PIC_MAX_LANES-1:0][PIC_POS_W-1:0] lanePos;
    logic                                    anyEdge;
    logic [PIC_POS_W-1:0]                    lastPos;
    logic                                    overflow;
  } scanCtrl_t;

endpackage

// File: rtl/pic_edge_ctrl.sv
module pic_edge_ctrl
  import photon_interval_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIC_WORD_W-1:0] sampleWord,
  output scanCtrl_t             ctrl
);

  localparam int HIT_W = PIC_POS_W + 1;
  localparam logic [HIT_W-1:0] LANES_C = HIT_W'(LANES);

  logic                  prevBit;
  logic                  haveRef;
  logic [PIC_WORD_W-1:0] earlierVec;
  logic [PIC_WORD_W-1:0] edgeVec;
  logic [HIT_W-1:0]      hitCount;
  scanCtrl_t             scan;

  // Each sample is compared with the one just before it in time.
  assign earlierVec = {sampleWord[PIC_WORD_W-2:0], prevBit};
  assign edgeVec    = sampleWord & ~earlierVec;

  always_comb begin
    scan     = '0;
    hitCount = '0;
    for (int i = 0; i < PIC_WORD_W; i++) begin
      if (edgeVec[i]) begin
        if (hitCount < LANES_C) begin
          scan.laneHit[hitCount[PIC_LANE_IDX_W-1:0]] = 1'b1;
          scan.lanePos[hitCount[PIC_LANE_IDX_W-1:0]] = PIC_POS_W'(i);
        end
        scan.lastPos = PIC_POS_W'(i);
        hitCount     = hitCount + HIT_W'(1);
      end
    end
    scan.anyEdge     = |edgeVec;
    scan.overflow    = hitCount > LANES_C;
    scan.laneFire    = scan.laneHit;
    // Without an earlier event the head lane has nothing to measure from.
    scan.laneFire[0] = scan.laneHit[0] & haveRef;
  end

  assign ctrl = scan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit <= 1'b0;
      haveRef <= 1'b0;
    end else begin
      prevBit <= sampleWord[PIC_WORD_W-1];
      if (scan.anyEdge) haveRef <= 1'b1;
    end
  end

  // R2 / R8: a line held high across the boundary yields no event.
  a_r8_high_no_edge: assert property (@(posedge clk) disable iff (!rstN)
    ((&sampleWord) && prevBit) |-> !ctrl.anyEdge);

  // R6: on overflow, the last event lies later than the last reported one.
  a_r6_drop_is_later: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.overflow |-> (ctrl.lastPos > ctrl.lanePos[LANES-1]));

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import photon_interval_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanCtrl_t              ctrl,
  output logic [LANES-1:0]       laneValid,
  output logic [LANES*CNT_W-1:0] laneData,
  output logic                   ovfFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   WORD_STEP = (CNT_W+1)'(PIC_WORD_W);

  logic [CNT_W-1:0] sinceLast;
  logic [CNT_W:0]   headSum;
  logic [CNT_W-1:0] headVal;
  logic [CNT_W:0]   idleSum;
  logic [CNT_W-1:0] nextSince;
  logic             unusedCtrl;

  // Head lane: samples since the last event, plus its offset in this word.
  assign headSum = {1'b0, sinceLast} + (CNT_W+1)'(ctrl.lanePos[0]);
  assign headVal = headSum[CNT_W] ? CNT_MAX : headSum[CNT_W-1:0];

  assign idleSum = {1'b0, sinceLast} + WORD_STEP;

  always_comb begin
    if (ctrl.anyEdge)
      nextSince = CNT_W'(PIC_WORD_W) - CNT_W'(ctrl.lastPos);
    else if (idleSum[CNT_W])
      nextSince = CNT_MAX;
    else
      nextSince = idleSum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLast <= '0;
      ovfFlag   <= 1'b0;
    end else begin
      sinceLast <= nextSince;
      ovfFlag   <= ctrl.overflow;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [CNT_W-1:0] laneVal;
    if (j == 0) begin : g_head
      assign laneVal = headVal;
    end else begin : g_follow
      assign laneVal = CNT_W'(ctrl.lanePos[j]) - CNT_W'(ctrl.lanePos[j-1]);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneValid[j]                <= 1'b0;
        laneData[j*CNT_W +: CNT_W]  <= '0;
      end else begin
        laneValid[j]                <= ctrl.laneFire[j];
        laneData[j*CNT_W +: CNT_W]  <= ctrl.laneFire[j] ? laneVal : '0;
      end
    end

    if (j > 0) begin : g_gap_chk
      // R5: two events in one word are 2 to WORD-1 samples apart.
      a_r5_inword_gap: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[j] |-> ((laneData[j*CNT_W +: CNT_W] >= CNT_W'(2)) &&
                          (laneData[j*CNT_W +: CNT_W] <= CNT_W'(PIC_WORD_W-1))));
    end
  end

  if (LANES > 1) begin : g_ovf_chk
    // R6: overflow only when every lane after the head is in use.
    a_r6_overflow_full: assert property (@(posedge clk) disable iff (!rstN)
      ovfFlag |-> (&laneValid[LANES-1:1]));
  end

  // R7: with no event the running count never moves backwards.
  a_r7_count_monotone: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.anyEdge |=> (sinceLast >= $past(sinceLast)));

  // R4: a reported head interval is never zero.
  a_r4_head_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    laneValid[0] |-> (laneData[CNT_W-1:0] != '0));

  assign unusedCtrl = ^ctrl.laneHit;

endmodule

// File: rtl/photon_interval_counter.sv
module photon_interval_counter
  import photon_interval_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             sampleWord,
  output logic [LANES-1:0]       intervalValid,
  output logic [LANES*CNT_W-1:0] intervalData,
  output logic                   overflowFlag
);

  scanCtrl_t scanCtrl;

  pic_edge_ctrl #(
    .LANES(LANES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleWord(sampleWord),
    .ctrl      (scanCtrl)
  );

  pic_datapath #(
    .LANES(LANES),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (scanCtrl),
    .laneValid(intervalValid),
    .laneData (intervalData),
    .ovfFlag  (overflowFlag)
  );

endmodule

// File: tb/photon_interval_counter_test.sv
module photon_interval_counter_test;

  localparam int LANES = 2;
  localparam int CNT_W = 16;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [7:0]             sampleWord = 8'h00;
  logic [LANES-1:0]       intervalValid;
  logic [LANES*CNT_W-1:0] intervalData;
  logic                   overflowFlag;

  int checks = 0;
  int fails  = 0;

  photon_interval_counter #(.LANES(LANES), .CNT_W(CNT_W)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .sampleWord   (sampleWord),
    .intervalValid(intervalValid),
    .intervalData (intervalData),
    .overflowFlag (overflowFlag)
  );

  always #2 clk = ~clk;

  task automatic checkVal(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Present a word before an edge; results are visible just after it.
  task automatic sendWord(logic [7:0] w);
    @(negedge clk);
    sampleWord = w;
    @(posedge clk);
    #1;
  endtask

  task automatic checkOut(string req, logic [1:0] expValid, int exp0, int exp1, logic expOvf);
    checkVal({req, " valid"}, int'(intervalValid), int'(expValid));
    if (expValid[0]) checkVal({req, " lane0"}, int'(intervalData[0 +: CNT_W]), exp0);
    if (expValid[1]) checkVal({req, " lane1"}, int'(intervalData[CNT_W +: CNT_W]), exp1);
    checkVal({req, " overflow"}, int'(overflowFlag), int'(expOvf));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleWord = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 in reset", 2'b00, 0, 0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    sampleWord = 8'h00;
    @(posedge clk);
    #1;
    checkOut("R1 after reset", 2'b00, 0, 0, 1'b0);
  endtask

  // R3, R4, R8: first event is reference only, cross-word interval.
  task automatic testFirstAndSpan();
    doReset();
    sendWord(8'hF0);
    checkOut("R3 first event silent", 2'b00, 0, 0, 1'b0);
    sendWord(8'hFF);
    checkOut("R8 high across boundary", 2'b00, 0, 0, 1'b0);
    sendWord(8'h00);
    sendWord(8'h00);
    sendWord(8'h01);
    checkOut("R4 span of 28", 2'b01, 28, 0, 1'b0);
  endtask

  // R5: two events in one word, lane order.
  task automatic testTwoInWord();
    sendWord(8'h00);
    sendWord(8'h66);
    checkOut("R5 two events", 2'b11, 17, 4, 1'b0);
  endtask

  // R6: four events in one word, reference follows the dropped ones.
  task automatic testOverflow();
    sendWord(8'h55);
    checkOut("R6 overflow word", 2'b11, 3, 2, 1'b1);
    sendWord(8'h80);
    checkOut("R6 from dropped edge", 2'b01, 9, 0, 1'b0);
  endtask

  // R2, R8: constant high, and bit7-high into bit0-high.
  task automatic testQuietLine();
    logic seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sendWord(8'hFF);
      if (intervalValid != '0) seen = 1'b1;
    end
    checkVal("R2 constant high no event", int'(seen), 0);
    sendWord(8'h80);
    sendWord(8'h01);
    checkOut("R8 bit7 high then bit0 high", 2'b00, 0, 0, 1'b0);
  endtask

  // R7: saturation then normal restart.
  task automatic testSaturate();
    logic seen = 1'b0;
    sendWord(8'h00);
    for (int k = 0; k < 9000; k++) begin
      sendWord(8'h00);
      if (intervalValid != '0) seen = 1'b1;
    end
    checkVal("R2 constant low no event", int'(seen), 0);
    sendWord(8'h08);
    checkOut("R7 saturated", 2'b01, 65535, 0, 1'b0);
    sendWord(8'h00);
    sendWord(8'h01);
    checkOut("R7 restart after saturation", 2'b01, 13, 0, 1'b0);
  endtask

  // R1, R3: reset mid-run clears the reference.
  task automatic testMidReset();
    doReset();
    sendWord(8'h01);
    checkOut("R3 first after mid reset", 2'b00, 0, 0, 1'b0);
    sendWord(8'h00);
    sendWord(8'h01);
    checkOut("R4 span of 16", 2'b01, 16, 0, 1'b0);
  endtask

  task automatic printSummary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    testFirstAndSpan();
    testTwoInWord();
    testOverflow();
    testQuietLine();
    testSaturate();
    testMidReset();
    printSummary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    printSummary();
    $finish;
  end

endmodule